// File: doc/BRIEF.md
# Correlation Result Readout Interface

This block passes complex correlation results from a signal-processing core to a host processor that reads them over an asynchronous, memory-mapped 16-bit bus. Each result has a 32-bit real part and a 32-bit imaginary part. When the core presents a new result, the block splits it into four 16-bit holding words and raises a ready flag toward the host.

The host sees the ready flag and reads the four words. It selects the block through the upper bits of its address bus and picks a word with the two lowest address bits. The block counts completed read strobes that were aimed at it. Once four reads have completed, it drops the ready flag until the next result arrives. The data bus is released to high impedance whenever the block is not addressed, so other devices can share the bus. If a new result arrives before the host has finished reading, the old words are overwritten and a sticky overrun flag is set.

Top module: `corrReadout`

## Requirements
- R1: After reset all four holding words read as zero, the ready flag is low, the overrun flag is low and the read count is zero.
- R2: A cycle with `resultValid` high captures `resultRe` and `resultIm`, and `dataReady` is high from the next clock edge onward.
- R3: While the block is addressed, word address 0 drives real[31:16], 1 drives real[15:0], 2 drives imaginary[31:16] and 3 drives imaginary[15:0] onto `hostData`.
- R4: The holding words change only when a new result is captured. Host reads leave them unchanged.
- R5: A read is counted when the active-low `hostRdN` returns high after a low phase during which the block was addressed. The strobe is sampled through a two-flop synchronizer. `dataReady` falls after the fourth counted read and stays low until the next capture. Reads made while `dataReady` is low are ignored.
- R6: The block is addressed when `hostAddr[7:2]` equals `CS_BASE`. Otherwise `hostData` is high impedance, and reads at other addresses are not counted.
- R7: A capture while `dataReady` is still high sets `overrun`, which then stays high until reset. The capture also restarts the read count, so four further reads are needed to clear `dataReady`.
- R8: When a capture and a counted read completion fall on the same clock edge, the capture wins: the count restarts at zero and `dataReady` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| resultValid | input | 1 | One-cycle strobe marking a new correlation result |
| resultRe | input | 32 | Real part of the new result |
| resultIm | input | 32 | Imaginary part of the new result |
| hostAddr | input | 8 | Host address; upper bits select the block, bits [1:0] pick a word |
| hostRdN | input | 1 | Active-low asynchronous host read strobe |
| hostData | output | 16 | Host data bus, high impedance when not addressed |
| dataReady | output | 1 | High while an unread result is waiting |
| overrun | output | 1 | Sticky flag: a result was replaced before it was fully read |

## Verification
The hardest case to reach from the ports is R8, where a new capture lands on the same core clock edge as the synchronized end of the fourth read strobe. Random timing hits this edge only by chance. The stimulus therefore releases the read strobe on a known falling clock edge and asserts `resultValid` exactly two cycles later, so the capture meets the edge-detect pulse that comes out of the synchronizer. Random sequences of captures, matching reads and reads at other addresses then cover overruns and ignored reads against a bench model.

// File: rtl/corrReadoutPkg.sv
package corrReadoutPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } ctrlStrb_t;
endpackage

// File: rtl/readSync.sv
module readSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut,
  output logic fallPulse
);
  logic [STAGES-1:0] stage;
  logic syncPrev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stage[0] <= 1'b0;
          else       stage[0] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) stage[i] <= 1'b0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= stage[STAGES-1];
  end

  assign syncOut   = stage[STAGES-1];
  assign fallPulse = syncPrev & ~stage[STAGES-1];
endmodule

// File: rtl/readoutCtrl.sv
module readoutCtrl
  import corrReadoutPkg::*;
#(
  parameter int NUM_WORDS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      resultValid,
  input  logic      selRead,
  output ctrlStrb_t strb,
  output logic      dataReady,
  output logic      overrun
);
  localparam int CNT_W = $clog2(NUM_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_WORDS - 1);

  logic             readSyncd;
  logic             readEnd;
  logic [CNT_W-1:0] readCount;

  readSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  (selRead),
    .syncOut  (readSyncd),
    .fallPulse(readEnd)
  );

  assign strb.load = resultValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readCount <= '0;
      dataReady <= 1'b0;
      overrun   <= 1'b0;
    end else if (resultValid) begin
      readCount <= '0;
      dataReady <= 1'b1;
      if (dataReady) overrun <= 1'b1;
    end else if (readEnd && dataReady) begin
      readCount <= readCount + 1'b1;
      if (readCount == LAST_IDX) dataReady <= 1'b0;
    end
  end

  // R2: capture raises the flag
  p_ready_after_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> dataReady);
  // R5: count never exceeds the word count
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    readCount <= CNT_W'(NUM_WORDS));
  // R5: last read drops the flag
  p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && readEnd && readCount == LAST_IDX && !resultValid) |=> !dataReady);
  // R5: flag stays low until a capture
  p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!dataReady && !resultValid) |=> !dataReady);
  // R7: overrun is sticky
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  // R8: capture on a read completion keeps the flag high
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && readEnd) |=> (dataReady && readCount == '0));
endmodule

// File: rtl/readoutDatapath.sv
module readoutDatapath
  import corrReadoutPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrb_t             strb,
  input  logic [DATA_W-1:0]     resultRe,
  input  logic [DATA_W-1:0]     resultIm,
  input  logic [$clog2(2*DATA_W/WORD_W)-1:0] wordSel,
  input  logic                  driveEn,
  output logic [WORD_W-1:0]     hostData
);
  localparam int HALVES    = DATA_W / WORD_W;
  localparam int NUM_WORDS = 2 * HALVES;

  logic [WORD_W-1:0] holdWord [NUM_WORDS];
  logic [NUM_WORDS*WORD_W-1:0] holdFlat;

  generate
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam int PART = i / HALVES;
      localparam int SLOT = HALVES - 1 - (i % HALVES);
      logic [DATA_W-1:0] src;
      if (PART == 0) begin : g_re
        assign src = resultRe;
      end else begin : g_im
        assign src = resultIm;
      end
      always_ff @(posedge clk) begin
        if (!rstN)          holdWord[i] <= '0;
        else if (strb.load) holdWord[i] <= src[SLOT*WORD_W +: WORD_W];
      end
      assign holdFlat[i*WORD_W +: WORD_W] = holdWord[i];
    end
  endgenerate

  assign hostData = driveEn ? holdWord[wordSel] : 'z;

  // R4: contents change only on capture
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(holdFlat));
endmodule

// File: rtl/corrReadout.sv
module corrReadout
  import corrReadoutPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int CS_BASE     = 42,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resultValid,
  input  logic [DATA_W-1:0] resultRe,
  input  logic [DATA_W-1:0] resultIm,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRdN,
  output logic [WORD_W-1:0] hostData,
  output logic              dataReady,
  output logic              overrun
);
  localparam int NUM_WORDS = 2 * DATA_W / WORD_W;
  localparam int WSEL_W    = $clog2(NUM_WORDS);
  localparam int CS_W      = ADDR_W - WSEL_W;
  localparam logic [CS_W-1:0] CS_MATCH = CS_W'(CS_BASE);

  ctrlStrb_t strb;
  logic      csHit;
  logic      selRead;

  assign csHit   = (hostAddr[ADDR_W-1:WSEL_W] == CS_MATCH);
  assign selRead = csHit & ~hostRdN;

  readoutCtrl #(.NUM_WORDS(NUM_WORDS), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .resultValid(resultValid),
    .selRead    (selRead),
    .strb       (strb),
    .dataReady  (dataReady),
    .overrun    (overrun)
  );

  readoutDatapath #(.DATA_W(DATA_W), .WORD_W(WORD_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .resultRe(resultRe),
    .resultIm(resultIm),
    .wordSel (hostAddr[WSEL_W-1:0]),
    .driveEn (csHit),
    .hostData(hostData)
  );
endmodule

// File: tb/tb_corrReadout.sv
module tb_corrReadout;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] CS = 6'd42;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resultValid = 1'b0;
  logic [31:0] resultRe = '0;
  logic [31:0] resultIm = '0;
  logic [7:0]  hostAddr = 8'h00;
  logic        hostRdN = 1'b1;
  wire  [15:0] busW;
  logic        dataReady, overrun;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] expRe = '0, expIm = '0;
  bit expReady = 1'b0, expOvr = 1'b0;
  int expCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  generate
    for (genvar b = 0; b < 16; b++) begin : g_pull
      pullup (busW[b]);
    end
  endgenerate

  corrReadout dut (
    .clk(clk), .rstN(rstN), .resultValid(resultValid),
    .resultRe(resultRe), .resultIm(resultIm),
    .hostAddr(hostAddr), .hostRdN(hostRdN),
    .hostData(busW), .dataReady(dataReady), .overrun(overrun)
  );

  function automatic logic [15:0] expWord(input logic [1:0] a);
    case (a)
      2'd0: return expRe[31:16];
      2'd1: return expRe[15:0];
      2'd2: return expIm[31:16];
      default: return expIm[15:0];
    endcase
  endfunction

  function automatic logic [5:0] missBase();
    logic [5:0] m;
    m = 6'($urandom_range(1, 63));
    return CS ^ m;
  endfunction

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkFlags(input string tag);
    checkVal({tag, " dataReady"}, 32'(dataReady), 32'(expReady));
    checkVal({tag, " overrun"}, 32'(overrun), 32'(expOvr));
  endtask

  task automatic modelLoad(input logic [31:0] re, input logic [31:0] im);
    if (expReady) expOvr = 1'b1;
    expRe = re; expIm = im; expReady = 1'b1; expCnt = 0;
  endtask

  task automatic doLoad(input logic [31:0] re, input logic [31:0] im);
    @(negedge clk);
    resultRe = re; resultIm = im; resultValid = 1'b1;
    @(negedge clk);
    resultValid = 1'b0;
    modelLoad(re, im);
  endtask

  // read one word; hit selects whether the block is addressed
  task automatic doRead(input bit hit, input logic [1:0] a, input string tag);
    @(negedge clk);
    hostAddr = {hit ? CS : missBase(), a};
    hostRdN = 1'b0;
    repeat (2) @(negedge clk);
    checkVal(tag, 32'(busW), hit ? 32'(expWord(a)) : 32'h0000FFFF);
    hostRdN = 1'b1;
    repeat (5) @(negedge clk);
    hostAddr = {missBase(), 2'd0};
    if (hit && expReady) begin
      expCnt++;
      if (expCnt == 4) expReady = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    hostAddr = {missBase(), 2'd0};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkFlags("R1 reset");
    for (int a = 0; a < 4; a++) doRead(1'b1, 2'(a), "R1 reset word");
    checkFlags("R1 R5 reads ignored while not ready");

    // R2, R3: capture and word map
    doLoad(32'h1234_5678, 32'h9ABC_DEF0);
    checkFlags("R2 after capture");
    for (int a = 0; a < 3; a++) doRead(1'b1, 2'(a), "R3 word map");
    checkFlags("R5 ready after three reads");
    doRead(1'b1, 2'd3, "R3 word map");
    checkFlags("R5 ready low after fourth read");

    // R4: contents held, reads ignored
    for (int a = 3; a >= 0; a--) doRead(1'b1, 2'(a), "R4 held word");
    checkFlags("R5 stays low");

    // R6: miss reads
    doLoad(32'hCAFE_0001, 32'h0BAD_F00D);
    for (int k = 0; k < 5; k++) doRead(1'b0, 2'(k), "R6 high impedance");
    checkFlags("R6 misses not counted");

    // R7: overrun
    doRead(1'b1, 2'd0, "R3 word map");
    doRead(1'b1, 2'd1, "R3 word map");
    doLoad(32'h0F0F_A5A5, 32'h7777_1111);
    checkFlags("R7 overrun set");
    for (int a = 0; a < 3; a++) doRead(1'b1, 2'(a), "R7 read after overrun");
    checkFlags("R7 count restarted");
    doRead(1'b1, 2'd3, "R7 read after overrun");
    checkFlags("R7 overrun sticky, ready low");

    // R8: capture on the same edge as the fourth read completion
    doLoad(32'h1111_2222, 32'h3333_4444);
    for (int a = 0; a < 3; a++) doRead(1'b1, 2'(a), "R8 setup read");
    @(negedge clk);
    hostAddr = {CS, 2'd3};
    hostRdN = 1'b0;
    repeat (2) @(negedge clk);
    hostRdN = 1'b1;
    repeat (2) @(negedge clk);
    resultRe = 32'h5555_6666; resultIm = 32'h7777_8888; resultValid = 1'b1;
    @(negedge clk);
    resultValid = 1'b0;
    repeat (4) @(negedge clk);
    hostAddr = {missBase(), 2'd0};
    modelLoad(32'h5555_6666, 32'h7777_8888);
    checkFlags("R8 capture wins");
    for (int a = 0; a < 3; a++) doRead(1'b1, 2'(a), "R8 new word");
    checkFlags("R8 still ready after three reads");
    doRead(1'b1, 2'd3, "R8 new word");
    checkFlags("R8 ready low after four reads");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 2) doLoad($urandom(), $urandom());
      else if (pick < 4) doRead(1'b0, 2'($urandom_range(0, 3)), "R6 random miss");
      else doRead(1'b1, 2'($urandom_range(0, 3)), "R3 R4 random read");
      checkFlags("R5 R7 random flags");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule